// File: doc/BRIEF.md
# Peak-Current Cycle-Skip and Hiccup Controller

This block is the digital overcurrent logic for one phase of a buck switcher. It runs on a reference clock. It watches a peak-current comparator flag (`oc_hs`) and a switching-cycle marker (`cycle_start`), and it grants or withdraws the high-side and low-side gate enables. A comparator trip removes both enables in the same clock. The block then blanks the rest of that cycle and skips at least the following whole cycle. It keeps skipping while the comparator stays high at each cycle boundary.

A counter tracks active cycles that end in a trip. A run of more than `TRIP_LIMIT` consecutive tripped active cycles starts a timed shutdown lasting `HICCUP_US` microseconds. The final `PULL_US` microseconds of that shutdown form a window in which the compensation node is pulled low and the soft-start node is discharged. When digital soft-start is chosen, the soft-start value is also reset during that window. A one-clock restart request then hands control to the external soft-start. In interleaved operation, a shutdown the phase starts on its own is exported to the paired phase. A shutdown request from the paired phase puts this phase into the same timed shutdown.

A small register holds the current-limit code that the analog comparator uses. The high-current variant accepts codes 0..4, meaning 2, 3, 4, 5 and 6 A, and resets to 4. The low-current variant accepts codes 0..3, meaning 0.5, 1, 2 and 3 A, and resets to 3.

States: RUN (both enables granted), BLANK (tripped, rest of cycle off), SKIP (whole cycle off), SHUT (hiccup, outputs quiet), PULL (hiccup, pulldown window), RESTART (one clock, restart request). Transitions:
- RUN→BLANK when `oc_hs` is high and the limit has not been reached.
- RUN→SHUT when `oc_hs` is high at the limit.
- BLANK→SKIP at `cycle_start`.
- SKIP→RUN at `cycle_start` with `oc_hs` low.
- SKIP→SKIP at `cycle_start` with `oc_hs` high.
- SHUT→PULL when the window opens.
- PULL→RESTART when the shutdown time has elapsed.
- RESTART→RUN after one clock.
- Any of RUN, BLANK, SKIP or RESTART →SHUT on a partner request while `interleave_en` is high.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: After reset, `hs_en` and `ls_en` are 1 and `comp_pulldown`, `ss_discharge`, `ss_reset`, `restart_req` and `partner_shutdown` are 0. `ilim_code` is 4 in the high-current variant and 3 in the low-current variant.
- R2: While `oc_hs` is high in RUN, `hs_en` and `ls_en` are 0 in the same clock. Both stay 0 until the next `cycle_start`, even after `oc_hs` falls.
- R3: The cycle that follows a trip is skipped: both enables stay 0 for that whole cycle, even if `oc_hs` is low.
- R4: At each `cycle_start` while skipping, a high `oc_hs` skips one more whole cycle. A low `oc_hs` restores both enables on the clock after that `cycle_start`.
- R5: A `cycle_start` in RUN (an active cycle ending without a trip) clears the trip count. Skipped cycles neither add to the count nor clear it. The (TRIP_LIMIT+1)-th consecutive tripped active cycle starts a hiccup; the TRIP_LIMIT-th does not.
- R6: A hiccup holds both enables at 0 for HICCUP_US×REF_KHZ/1000 clocks. `comp_pulldown` and `ss_discharge` are 1 for exactly the last PULL_US×REF_KHZ/1000 of those clocks. `cycle_start` has no effect during a hiccup.
- R7: `ss_reset` is 1 only inside the pulldown window, and only when `ss_digital` is 1.
- R8: `restart_req` is a single-clock pulse on the clock after the pulldown window. Both enables return on the following clock, and the trip count restarts from zero.
- R9: `partner_shutdown` is 1 for the whole of a hiccup that this phase started itself, and only while `interleave_en` is 1. It is 0 during a hiccup started by the partner.
- R10: `partner_hiccup` with `interleave_en` high starts a hiccup of the same length on the next clock. With `interleave_en` low it has no effect.
- R11: A write of `cfg_code` with `cfg_we` high updates `ilim_code` on the next clock when the code is legal. In the high-current variant the legal codes are 0..4 (2, 3, 4, 5, 6 A). In the low-current variant they are 0..3 (0.5, 1, 2, 3 A). Illegal codes and cycles with `cfg_we` low leave `ilim_code` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_start | input | 1 | One-clock marker at each switching-cycle boundary |
| oc_hs | input | 1 | Peak-current comparator flag |
| partner_hiccup | input | 1 | Shutdown request from the interleaved partner |
| interleave_en | input | 1 | Phase runs interleaved with a partner |
| ss_digital | input | 1 | Digital soft-start selected |
| cfg_we | input | 1 | Limit-code write strobe |
| cfg_code | input | 3 | Limit code to write |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| comp_pulldown | output | 1 | Pull compensation node low |
| ss_discharge | output | 1 | Discharge soft-start node |
| ss_reset | output | 1 | Reset digital soft-start value |
| restart_req | output | 1 | One-clock soft-start restart request |
| partner_shutdown | output | 1 | Shutdown request to the partner |
| ilim_code | output | 3 | Current-limit code to the comparator |

## Verification
The trip path is tried with three patterns:
- A single trip followed by a clean skipped cycle. This separates immediate blanking from the compulsory skip.
- A comparator held high across skip boundaries. This separates one skip from repeated skips.
- Trip runs of length TRIP_LIMIT and TRIP_LIMIT+1, with and without a clean active cycle between them. This separates clearing of the count from mere saturation and locates the escalation boundary.

Hiccups are started by the phase itself and by the partner, with the interleave and soft-start mode inputs varied. The edge clocks of the pulldown window and of the restart pulse are checked, and so is the export to the partner. The limit register is driven with legal codes, illegal codes and idle strobes in both range variants.

// File: rtl/ocp_pkg.sv
`timescale 1ns/1ps
package ocp_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_BLANK   = 3'd1,
        ST_SKIP    = 3'd2,
        ST_SHUT    = 3'd3,
        ST_PULL    = 3'd4,
        ST_RESTART = 3'd5
    } ocp_state_e;

    localparam int CODE_W = 3;

endpackage

// File: rtl/ocp_ilim_reg.sv
`timescale 1ns/1ps
module ocp_ilim_reg import ocp_pkg::*; #(
    parameter bit HIGH_RANGE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_q
);
    localparam logic [CODE_W-1:0] CODE_MAX = HIGH_RANGE ? CODE_W'(4) : CODE_W'(3);
    localparam logic [CODE_W-1:0] CODE_DEF = CODE_MAX;

    logic legal;
    assign legal = (code_in <= CODE_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= CODE_DEF;
        end else if (we && legal) begin
            code_q <= code_in;
        end
    end

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        code_q <= CODE_MAX); // R11
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(code_q)); // R11

endmodule

// File: rtl/ocp_trip_counter.sv
`timescale 1ns/1ps
module ocp_trip_counter #(
    parameter int TRIP_LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_all,
    input  logic clr_clean,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(TRIP_LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(TRIP_LIMIT);

    logic [CW-1:0] cnt_q;

    // A clean cycle end and a trip in the next cycle, both in one clock, leave a count of one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_all) begin
            cnt_q <= '0;
        end else if (clr_clean && inc) begin
            cnt_q <= CW'(1);
        end else if (clr_clean) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q < LIM)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign at_limit = (cnt_q == LIM);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM); // R5
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_clean && !inc) |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/ocp_hiccup_timer.sv
`timescale 1ns/1ps
module ocp_hiccup_timer #(
    parameter int TOTAL_CYC = 1000,
    parameter int PULL_CYC  = 55
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic win_open,
    output logic done
);
    localparam int TW       = $clog2(TOTAL_CYC + 1);
    localparam int SHUT_CYC = TOTAL_CYC - PULL_CYC;
    localparam logic [TW-1:0] LAST    = TW'(TOTAL_CYC - 1);
    localparam logic [TW-1:0] WIN_AT  = TW'(SHUT_CYC - 1);

    logic [TW-1:0] t_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else if (!en) begin
            t_q <= '0;
        end else if (t_q != LAST) begin
            t_q <= t_q + TW'(1);
        end
    end

    assign win_open = en && (t_q == WIN_AT);
    assign done     = en && (t_q == LAST);

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        t_q <= LAST); // R6
    AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (t_q == '0)); // R6

endmodule

// File: rtl/ocp_hiccup_ctrl.sv
`timescale 1ns/1ps
module ocp_hiccup_ctrl import ocp_pkg::*; #(
    parameter int  TRIP_LIMIT = 256,
    parameter int  REF_KHZ    = 50000,
    parameter int  HICCUP_US  = 20000,
    parameter int  PULL_US    = 1100,
    parameter bit  HIGH_RANGE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cycle_start,
    input  logic              oc_hs,
    input  logic              partner_hiccup,
    input  logic              interleave_en,
    input  logic              ss_digital,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_code,
    output logic              hs_en,
    output logic              ls_en,
    output logic              comp_pulldown,
    output logic              ss_discharge,
    output logic              ss_reset,
    output logic              restart_req,
    output logic              partner_shutdown,
    output logic [CODE_W-1:0] ilim_code
);
    localparam int HICCUP_CYC = REF_KHZ * HICCUP_US / 1000;
    localparam int PULL_CYC   = REF_KHZ * PULL_US / 1000;

    ocp_state_e state_q, state_d;
    logic       self_q, self_d;
    logic       at_limit, win_open, hic_done;
    logic       in_hiccup, partner_req, trip, entering;

    assign in_hiccup   = (state_q == ST_SHUT) || (state_q == ST_PULL);
    assign partner_req = interleave_en && partner_hiccup;
    assign trip        = (state_q == ST_RUN) && oc_hs;
    assign entering    = (state_d == ST_SHUT) && !in_hiccup;

    ocp_ilim_reg #(.HIGH_RANGE(HIGH_RANGE)) u_ilim (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .code_in (cfg_code),
        .code_q  (ilim_code)
    );

    ocp_trip_counter #(.TRIP_LIMIT(TRIP_LIMIT)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (entering),
        .clr_clean ((state_q == ST_RUN) && cycle_start),
        .inc       (trip),
        .at_limit  (at_limit)
    );

    ocp_hiccup_timer #(.TOTAL_CYC(HICCUP_CYC), .PULL_CYC(PULL_CYC)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (in_hiccup),
        .win_open (win_open),
        .done     (hic_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            self_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            self_q  <= self_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        self_d  = self_q;
        unique case (state_q)
            ST_RUN: begin
                if (oc_hs && at_limit) begin
                    state_d = ST_SHUT;
                    self_d  = 1'b1;
                end else if (oc_hs) begin
                    state_d = ST_BLANK;
                end
            end
            ST_BLANK:   if (cycle_start) state_d = ST_SKIP;
            ST_SKIP:    if (cycle_start && !oc_hs) state_d = ST_RUN;
            ST_SHUT:    if (win_open) state_d = ST_PULL;
            ST_PULL:    if (hic_done) state_d = ST_RESTART;
            ST_RESTART: state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
        if (partner_req && !in_hiccup && !(state_d == ST_SHUT && self_d)) begin
            state_d = ST_SHUT;
            self_d  = 1'b0;
        end
    end

    // Outputs
    always_comb begin
        hs_en            = 1'b0;
        ls_en            = 1'b0;
        comp_pulldown    = 1'b0;
        ss_discharge     = 1'b0;
        ss_reset         = 1'b0;
        restart_req      = 1'b0;
        partner_shutdown = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                hs_en = !oc_hs;
                ls_en = !oc_hs;
            end
            ST_BLANK, ST_SKIP: begin
                hs_en = 1'b0;
            end
            ST_SHUT: begin
                partner_shutdown = self_q && interleave_en;
            end
            ST_PULL: begin
                comp_pulldown    = 1'b1;
                ss_discharge     = 1'b1;
                ss_reset         = ss_digital;
                partner_shutdown = self_q && interleave_en;
            end
            ST_RESTART: begin
                restart_req = 1'b1;
            end
            default: begin
                hs_en = 1'b0;
            end
        endcase
    end

    AST_TRIP_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oc_hs |-> (!hs_en && !ls_en)); // R2
    AST_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        comp_pulldown |-> (!hs_en && !ls_en && ss_discharge)); // R6
    AST_SSRESET_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ss_reset |-> (comp_pulldown && ss_digital)); // R7
    AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req); // R8
    AST_RESTART_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restart_req) |-> $past(comp_pulldown)); // R8
    AST_PARTNER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        partner_shutdown |-> (interleave_en && !hs_en && !ls_en)); // R9
    AST_PARTNER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (partner_req && hs_en && !oc_hs) |=> (!hs_en && !partner_shutdown)); // R10

endmodule

// File: tb/test_ocp_hiccup_ctrl.sv
`timescale 1ns/1ps
module test_ocp_hiccup_ctrl;
    localparam int LIM   = 4;
    localparam int TOT   = 200;   // 10 kHz reference: 20 ms
    localparam int PULLC = 11;    // 1.1 ms

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cycle_start = 1'b0, oc_hs = 1'b0, partner_hiccup = 1'b0;
    logic interleave_en = 1'b0, ss_digital = 1'b0;
    logic cfg_we = 1'b0, cfg_we_lo = 1'b0;
    logic [2:0] cfg_code = '0;
    logic hs_en, ls_en, comp_pulldown, ss_discharge, ss_reset, restart_req, partner_shutdown;
    logic [2:0] ilim_code;
    logic lo_hs, lo_ls, lo_cp, lo_sd, lo_sr, lo_rr, lo_ps;
    logic [2:0] lo_code;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ocp_hiccup_ctrl #(.TRIP_LIMIT(LIM), .REF_KHZ(10), .HICCUP_US(20000), .PULL_US(1100),
                      .HIGH_RANGE(1'b1)) i_ocp_hiccup_ctrl (
        .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .oc_hs(oc_hs),
        .partner_hiccup(partner_hiccup), .interleave_en(interleave_en), .ss_digital(ss_digital),
        .cfg_we(cfg_we), .cfg_code(cfg_code), .hs_en(hs_en), .ls_en(ls_en),
        .comp_pulldown(comp_pulldown), .ss_discharge(ss_discharge), .ss_reset(ss_reset),
        .restart_req(restart_req), .partner_shutdown(partner_shutdown), .ilim_code(ilim_code));

    ocp_hiccup_ctrl #(.TRIP_LIMIT(LIM), .REF_KHZ(10), .HICCUP_US(20000), .PULL_US(1100),
                      .HIGH_RANGE(1'b0)) i_ocp_hiccup_ctrl_lo (
        .clk(clk), .rst_n(rst_n), .cycle_start(1'b0), .oc_hs(1'b0),
        .partner_hiccup(1'b0), .interleave_en(1'b0), .ss_digital(1'b0),
        .cfg_we(cfg_we_lo), .cfg_code(cfg_code), .hs_en(lo_hs), .ls_en(lo_ls),
        .comp_pulldown(lo_cp), .ss_discharge(lo_sd), .ss_reset(lo_sr),
        .restart_req(lo_rr), .partner_shutdown(lo_ps), .ilim_code(lo_code));

    // {we, code, expected ilim_code}
    localparam logic [6:0] VEC [8] = '{
        {1'b1, 3'd0, 3'd0}, {1'b1, 3'd2, 3'd2}, {1'b1, 3'd5, 3'd2}, {1'b0, 3'd1, 3'd2},
        {1'b1, 3'd7, 3'd2}, {1'b1, 3'd4, 3'd4}, {1'b1, 3'd1, 3'd1}, {1'b1, 3'd3, 3'd3}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_cycle();
        cycle_start = 1'b1;
        clks(1);
        cycle_start = 1'b0;
    endtask

    // One tripped active cycle from RUN, then a clean skipped cycle, back in RUN.
    task automatic trip_round();
        clks(1);
        oc_hs = 1'b1;
        clks(1);
        oc_hs = 1'b0;
        pulse_cycle();
        clks(2);
        pulse_cycle();
        clks(1);
    endtask

    task automatic check_hiccup(input string tag, input bit exp_ps, input bit exp_sr);
        // called on the negedge after the entry edge (P1)
        chk({tag, " R6 gates off at entry"}, hs_en | ls_en, 0);
        chk({tag, " R9 partner_shutdown"}, partner_shutdown, exp_ps);
        clks(50);
        cycle_start = 1'b1;
        clks(1);
        cycle_start = 1'b0;
        chk({tag, " R6 cycle_start ignored"}, hs_en, 0);
        clks(TOT - PULLC - 52);
        chk({tag, " R6 window not yet open"}, comp_pulldown, 0);
        clks(1);
        chk({tag, " R6 pulldown opens"}, comp_pulldown, 1);
        chk({tag, " R6 discharge opens"}, ss_discharge, 1);
        chk({tag, " R7 ss_reset"}, ss_reset, exp_sr);
        chk({tag, " R9 partner_shutdown in window"}, partner_shutdown, exp_ps);
        clks(PULLC - 1);
        chk({tag, " R6 pulldown last clock"}, comp_pulldown, 1);
        clks(1);
        chk({tag, " R6 pulldown closed"}, comp_pulldown, 0);
        chk({tag, " R8 restart pulse"}, restart_req, 1);
        chk({tag, " R8 gates still off"}, hs_en, 0);
        clks(1);
        chk({tag, " R8 restart single"}, restart_req, 0);
        chk({tag, " R8 gates back"}, hs_en & ls_en, 1);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run ended)");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        clks(3);
        rst_n = 1'b1;
        clks(1);
        // R1 reset state
        chk("R1 hs_en", hs_en, 1);
        chk("R1 ls_en", ls_en, 1);
        chk("R1 quiet outputs", comp_pulldown | ss_discharge | ss_reset | restart_req | partner_shutdown, 0);
        chk("R1 high default code", ilim_code, 4);
        chk("R1 low default code", lo_code, 3);

        // R11 register vector table
        for (int i = 0; i < 8; i++) begin
            cfg_we = VEC[i][6];
            cfg_code = VEC[i][5:3];
            clks(1);
            cfg_we = 1'b0;
            chk("R11 high code table", ilim_code, VEC[i][2:0]);
        end
        cfg_code = 3'd4; cfg_we_lo = 1'b1; clks(1); cfg_we_lo = 1'b0;
        chk("R11 low range rejects 4", lo_code, 3);
        cfg_code = 3'd0; cfg_we_lo = 1'b1; clks(1); cfg_we_lo = 1'b0;
        chk("R11 low range accepts 0", lo_code, 0);

        // R2 / R3 / R4: single trip
        pulse_cycle();
        clks(1);
        oc_hs = 1'b1;
        #1;
        chk("R2 immediate gate drop", hs_en | ls_en, 0);
        clks(1);
        oc_hs = 1'b0;
        clks(1);
        chk("R2 held off after comparator falls", hs_en | ls_en, 0);
        pulse_cycle();
        clks(3);
        chk("R3 skipped cycle with low current", hs_en | ls_en, 0);
        pulse_cycle();
        chk("R4 enables back after skip", hs_en & ls_en, 1);

        // R4: repeated skip while current stays high
        clks(1);
        oc_hs = 1'b1;
        clks(1);
        pulse_cycle();
        pulse_cycle();
        clks(1);
        chk("R4 second skip with high current", hs_en | ls_en, 0);
        oc_hs = 1'b0;
        clks(1);
        chk("R4 still skipping inside cycle", hs_en, 0);
        pulse_cycle();
        chk("R4 resume once current low", hs_en, 1);

        // R5: clean cycle clears count; limit boundary
        pulse_cycle();               // clean active cycle end: count 0
        repeat (3) trip_round();
        pulse_cycle();               // clears again
        repeat (LIM) trip_round();
        chk("R5 limit count alone no hiccup", hs_en, 1);
        chk("R5 no window at limit", comp_pulldown, 0);

        // R5 / R6 / R7 / R8 / R9: own hiccup, interleaved, digital soft-start
        interleave_en = 1'b1;
        ss_digital = 1'b1;
        clks(1);
        oc_hs = 1'b1;
        clks(1);
        oc_hs = 1'b0;
        chk("R5 escalation to hiccup", comp_pulldown | hs_en, 0);
        check_hiccup("own", 1'b1, 1'b1);

        // R8: count restarted from zero
        repeat (LIM) trip_round();
        chk("R8 count cleared by hiccup", hs_en, 1);
        pulse_cycle();

        // R10: partner request ignored without interleave
        interleave_en = 1'b0;
        partner_hiccup = 1'b1;
        clks(3);
        chk("R10 partner ignored", hs_en, 1);
        chk("R10 partner ignored window", comp_pulldown, 0);
        partner_hiccup = 1'b0;
        clks(1);

        // R10 / R9 / R7: partner-started hiccup, analog soft-start
        interleave_en = 1'b1;
        ss_digital = 1'b0;
        partner_hiccup = 1'b1;
        clks(1);
        partner_hiccup = 1'b0;
        chk("R10 partner forces shutdown", hs_en, 0);
        check_hiccup("partner", 1'b0, 1'b0);

        // R9: own hiccup with interleave off exports nothing
        interleave_en = 1'b0;
        pulse_cycle();
        repeat (LIM) trip_round();
        clks(1);
        oc_hs = 1'b1;
        clks(1);
        oc_hs = 1'b0;
        check_hiccup("solo", 1'b0, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule